// File: doc/BRIEF.md
# Write-Through Data Cache Controller

This block sits between a processor's load/store port and a pipelined Wishbone bus master. It keeps a direct-mapped copy of recently read memory lines. A cacheable read that finds its line resident is answered from local storage. A cacheable read that misses first loads the whole line over the bus in one burst, and then returns the requested word. Stores are always forwarded to the bus. A store also updates the local copy, but only when that line is already resident; a store never allocates a line. Accesses flagged as non-cacheable skip the cache completely and become one single-word bus transaction.

The processor presents one request at a time: a word address, a write flag, a cacheable flag and, for writes, the data. A request is taken only in a cycle where `busy` is low. `busy` stays high until the single-cycle response pulse, and in that pulse cycle `busy` is already low again. Residency is decided over two clocks: the tag table is read in the first, and the stored tag is compared with the request in the second.

Top module: `wt_dcache`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `resp_valid` and `wb_cyc` are all low.
- R2: A request is accepted in a cycle where `req_valid` is high and `busy` is low. For a cacheable read hit, `resp_valid` is high exactly 3 cycles after the acceptance cycle, and no bus read is issued. For any cacheable access, `wb_cyc` stays low for the 2 cycles that follow acceptance.
- R3: A cacheable read miss issues exactly LINE_WORDS (8) bus reads. Their addresses start at the line-aligned address (the request address with the low 3 bits cleared) and stay within that line. The response then carries the bus data for the requested word.
- R4: Every write makes exactly one bus write carrying the request's address and data. A cacheable write updates a resident line, so a later read of that word hits and returns the new data. A write to a non-resident line does not allocate it, so a later read of that line misses.
- R5: A non-cacheable access raises `wb_cyc` in the cycle right after acceptance, as one single-word transaction. A non-cacheable write leaves the cached copy unchanged. A non-cacheable read returns the bus data.
- R6: `resp_valid` is a one-cycle pulse, and `busy` is low in that cycle.
- R7: A bus error during a line fill ends the fill and responds with `resp_err`=1. That line stays invalid, so the next read of it fills again.
- R8: After reset every line is invalid, so the first read of any address misses.
- R9: A request held on `req_valid` while `busy` is high is ignored. It causes no bus transaction and no response.
- R10: `wb_stb` is only ever high together with `wb_cyc`, and `wb_cyc` drops after the last acknowledge or after an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_cacheable | input | 1 | 1 = may use the cache |
| req_addr | input | 30 | Word address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | A request is in progress |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Response reports a bus error |
| resp_data | output | 32 | Read data, valid with `resp_valid` on reads |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus request strobe |
| wb_we | output | 1 | Bus write |
| wb_addr | output | 30 | Bus word address |
| wb_wdata | output | 32 | Bus write data |
| wb_stall | input | 1 | Bus cannot accept the strobe this cycle |
| wb_ack | input | 1 | Bus acknowledge with data |
| wb_rdata | input | 32 | Bus read data |
| wb_err | input | 1 | Bus error |

## Verification
The cache is exercised with several patterns. A cold read tells a miss from a hit by the count of bus reads. A repeat read inside the same line must give the fixed three-cycle hit latency. Writes go to both resident and non-resident lines, which separates update-in-place from allocation. A non-cacheable store to a cached word must not change the cached copy, while a non-cacheable read must still return the new memory value. Two lines that share an index must evict each other, an error injected in the middle of a fill must leave the line invalid, and a request held during a fill must be ignored. The bus model stalls and delays acknowledges on a fixed pattern, so that the fill order does not depend on zero-wait timing.

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int LINE_WORDS = 8,
  parameter int LINES      = 32,
  parameter int DW         = 32,
  parameter int AW         = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic          req_cacheable,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          resp_valid,
  output logic          resp_err,
  output logic [DW-1:0] resp_data,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_wdata,
  input  logic          wb_stall,
  input  logic          wb_ack,
  input  logic [DW-1:0] wb_rdata,
  input  logic          wb_err
);
  localparam int OFFW  = $clog2(LINE_WORDS);
  localparam int IDXW  = $clog2(LINES);
  localparam int TAGW  = AW - OFFW - IDXW;
  localparam int DEPTH = LINES * LINE_WORDS;
  localparam logic [OFFW-1:0] LAST = OFFW'(LINE_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_TAG, S_CMP, S_FILL, S_FRD, S_SGL} st_t;

  st_t st;
  logic            r_we, hit_r, from_bus, vld_q;
  logic [AW-1:0]   r_addr;
  logic [DW-1:0]   r_wdata, mem_q, s_q;
  logic [TAGW-1:0] tags [LINES];
  logic [TAGW-1:0] tag_q;
  logic [LINES-1:0] vld;
  logic [DW-1:0]   mem [DEPTH];
  logic [OFFW-1:0] n_ack;

  wire [TAGW-1:0] r_tag = r_addr[AW-1 -: TAGW];
  wire [IDXW-1:0] r_idx = r_addr[OFFW +: IDXW];
  wire [OFFW-1:0] r_off = r_addr[OFFW-1:0];
  wire            hit   = vld_q && (tag_q == r_tag);
  wire            fill_start = (st == S_CMP) && !r_we && !hit;

  wire                  mem_we = wb_ack && ((st == S_FILL) || (st == S_SGL && r_we && hit_r));
  wire [IDXW+OFFW-1:0]  mem_wa = (st == S_FILL) ? {r_idx, n_ack} : {r_idx, r_off};
  wire [DW-1:0]         mem_wd = (st == S_FILL) ? wb_rdata : r_wdata;

  assign busy      = (st != S_IDLE);
  assign resp_data = from_bus ? s_q : mem_q;

  always_ff @(posedge clk) begin
    tag_q <= tags[r_idx];
    vld_q <= vld[r_idx];
    if (fill_start) tags[r_idx] <= r_tag;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
    mem_q <= mem[{r_idx, r_off}];
    if (st == S_SGL && wb_ack) s_q <= wb_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wb_cyc <= 1'b0;
      wb_stb <= 1'b0;
      wb_we <= 1'b0;
      resp_valid <= 1'b0;
      resp_err <= 1'b0;
      vld <= '0;
      hit_r <= 1'b0;
      from_bus <= 1'b0;
      n_ack <= '0;
    end else begin
      resp_valid <= 1'b0;
      from_bus <= (st == S_SGL);
      case (st)
        S_IDLE: if (req_valid) begin
          r_we <= req_we;
          r_addr <= req_addr;
          r_wdata <= req_wdata;
          hit_r <= 1'b0;
          if (req_cacheable) st <= S_TAG;
          else begin
            st <= S_SGL;
            wb_cyc <= 1'b1;
            wb_stb <= 1'b1;
            wb_we <= req_we;
            wb_addr <= req_addr;
            wb_wdata <= req_wdata;
          end
        end
        S_TAG: st <= S_CMP;
        S_CMP: begin
          hit_r <= hit;
          if (r_we) begin
            st <= S_SGL;
            wb_cyc <= 1'b1;
            wb_stb <= 1'b1;
            wb_we <= 1'b1;
            wb_addr <= r_addr;
            wb_wdata <= r_wdata;
          end else if (hit) begin
            st <= S_IDLE;
            resp_valid <= 1'b1;
            resp_err <= 1'b0;
          end else begin
            st <= S_FILL;
            vld[r_idx] <= 1'b0;
            wb_cyc <= 1'b1;
            wb_stb <= 1'b1;
            wb_we <= 1'b0;
            wb_addr <= {r_addr[AW-1:OFFW], {OFFW{1'b0}}};
            n_ack <= '0;
          end
        end
        S_FILL: begin
          if (wb_stb && !wb_stall) begin
            if (wb_addr[OFFW-1:0] == LAST) wb_stb <= 1'b0;
            else wb_addr <= wb_addr + 1'b1;
          end
          if (wb_err) begin
            wb_cyc <= 1'b0;
            wb_stb <= 1'b0;
            st <= S_IDLE;
            resp_valid <= 1'b1;
            resp_err <= 1'b1;
          end else if (wb_ack) begin
            n_ack <= n_ack + 1'b1;
            if (n_ack == LAST) begin
              wb_cyc <= 1'b0;
              vld[r_idx] <= 1'b1;
              st <= S_FRD;
            end
          end
        end
        S_FRD: begin
          st <= S_IDLE;
          resp_valid <= 1'b1;
          resp_err <= 1'b0;
        end
        S_SGL: begin
          if (wb_stb && !wb_stall) wb_stb <= 1'b0;
          if (wb_ack || wb_err) begin
            wb_cyc <= 1'b0;
            wb_stb <= 1'b0;
            st <= S_IDLE;
            resp_valid <= 1'b1;
            resp_err <= wb_err;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_stb_inside_cyc: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> wb_cyc);

  a_r6_resp_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !busy);

  a_r6_resp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r2_no_early_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_cacheable) |=> !wb_cyc ##1 !wb_cyc);

  a_r5_bypass_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_cacheable) |=> (wb_cyc && wb_stb && wb_addr == $past(req_addr)));

  a_r3_fill_within_line: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && wb_stb) |-> (!wb_we && wb_addr[AW-1:OFFW] == r_addr[AW-1:OFFW]));

  a_r7_err_drops_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_err) |=> !wb_cyc);
endmodule

// File: tb/sim_wt_dcache.sv
module sim_wt_dcache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_cacheable = 1'b0;
  logic [29:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic busy, resp_valid, resp_err;
  logic [31:0] resp_data;
  logic wb_cyc, wb_stb, wb_we;
  logic [29:0] wb_addr;
  logic [31:0] wb_wdata;
  logic wb_stall = 1'b0, wb_ack = 1'b0, wb_err = 1'b0;
  logic [31:0] wb_rdata = '0;

  always #5 clk = ~clk;

  wt_dcache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_cacheable(req_cacheable), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .resp_valid(resp_valid), .resp_err(resp_err), .resp_data(resp_data),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_addr(wb_addr),
    .wb_wdata(wb_wdata), .wb_stall(wb_stall), .wb_ack(wb_ack),
    .wb_rdata(wb_rdata), .wb_err(wb_err)
  );

  int n_chk = 0, n_fail = 0;
  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model
  logic [31:0] wmem [logic [29:0]];
  function automatic logic [31:0] rd_model(input logic [29:0] a);
    if (wmem.exists(a)) return wmem[a];
    return {a[15:0], ~a[15:0]} ^ 32'h1357_2468;
  endfunction

  // bus slave
  int scnt = 0, n_rd = 0, n_wr = 0;
  logic err_on = 1'b0;
  logic [29:0] err_addr = '0, first_addr = '0;
  logic first_pending = 1'b1;
  logic [29:0] pend [$];
  always @(posedge clk) begin
    scnt <= scnt + 1;
    wb_stall <= (scnt % 5 == 2);
    if (!wb_cyc) begin
      pend.delete();
      wb_ack <= 1'b0;
      wb_err <= 1'b0;
      first_pending = 1'b1;
    end else begin
      if (pend.size() > 0 && (scnt % 7 != 3)) begin
        logic [29:0] a;
        a = pend.pop_front();
        if (err_on && a == err_addr) begin
          wb_err <= 1'b1;
          wb_ack <= 1'b0;
        end else begin
          wb_ack <= 1'b1;
          wb_err <= 1'b0;
          wb_rdata <= rd_model(a);
        end
      end else begin
        wb_ack <= 1'b0;
        wb_err <= 1'b0;
      end
      if (wb_stb && !wb_stall) begin
        pend.push_back(wb_addr);
        if (wb_we) begin
          wmem[wb_addr] = wb_wdata;
          n_wr++;
        end else n_rd++;
        if (first_pending) begin
          first_addr = wb_addr;
          first_pending = 1'b0;
        end
      end
    end
  end

  int cyc_n = 0, rise_cyc = 0, resp_cyc = 0, n_resp = 0;
  logic cyc_prev = 1'b0;
  always @(posedge clk) cyc_n++;
  always @(negedge clk) begin
    if (wb_cyc && !cyc_prev) rise_cyc = cyc_n;
    cyc_prev = wb_cyc;
  end

  // scoreboard
  logic        exp_err_q [$];
  logic [31:0] exp_dat_q [$];
  logic        exp_chk_q [$];
  string       exp_req_q [$];
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      resp_cyc = cyc_n;
      n_resp++;
      check("R6 busy low with response", !busy, {31'd0, busy}, 32'd0);
      if (exp_err_q.size() == 0) begin
        check("R9 unexpected response", 1'b0, resp_data, 32'd0);
      end else begin
        logic e, c;
        logic [31:0] d;
        string r;
        e = exp_err_q.pop_front();
        d = exp_dat_q.pop_front();
        c = exp_chk_q.pop_front();
        r = exp_req_q.pop_front();
        check({r, " error flag"}, resp_err == e, {31'd0, resp_err}, {31'd0, e});
        if (c) check({r, " data"}, resp_data == d, resp_data, d);
      end
    end
  end

  int acc_cyc = 0, lat = 0, d_rd = 0, d_wr = 0;
  task automatic issue(input logic we, input logic cch, input logic [29:0] a, input logic [31:0] wd,
                       input logic e, input logic [31:0] d, input logic c, input string r);
    int n0, rd0, wr0;
    @(negedge clk);
    while (busy) @(negedge clk);
    n0 = n_resp; rd0 = n_rd; wr0 = n_wr;
    req_valid = 1'b1; req_we = we; req_cacheable = cch; req_addr = a; req_wdata = wd;
    acc_cyc = cyc_n;
    exp_err_q.push_back(e); exp_dat_q.push_back(d); exp_chk_q.push_back(c); exp_req_q.push_back(r);
    @(negedge clk);
    req_valid = 1'b0;
    while (n_resp == n0) begin
      @(negedge clk);
      #1;
    end
    lat = resp_cyc - acc_cyc;
    d_rd = n_rd - rd0;
    d_wr = n_wr - wr0;
  endtask

  localparam logic [29:0] A = 30'h100, B = 30'h248, C = 30'h200, D = 30'h3A0, E = 30'h518, F = 30'h777;

  initial begin
    logic [31:0] old;
    int wr0, n0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", !busy, {31'd0, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", !busy, {31'd0, busy}, 0);
    check("R1 no bus cycle", !wb_cyc, {31'd0, wb_cyc}, 0);
    check("R1 no response", !resp_valid, {31'd0, resp_valid}, 0);

    issue(0, 1, A + 3, 0, 0, rd_model(A + 3), 1, "R8 cold read");
    check("R8 cold read fills line", d_rd == 8, d_rd, 8);
    check("R2 bus not before third cycle", rise_cyc - acc_cyc == 3, rise_cyc - acc_cyc, 3);
    check("R3 fill starts line-aligned", first_addr == A, {2'b0, first_addr}, {2'b0, A});

    issue(0, 1, A + 5, 0, 0, rd_model(A + 5), 1, "R2 hit data");
    check("R2 hit latency", lat == 3, lat, 3);
    check("R2 hit makes no bus read", d_rd == 0, d_rd, 0);

    issue(1, 1, A + 5, 32'hCAFE_0001, 0, 0, 0, "R4 resident write");
    check("R4 one bus write", d_wr == 1, d_wr, 1);
    issue(0, 1, A + 5, 0, 0, 32'hCAFE_0001, 1, "R4 read after resident write");
    check("R4 updated word still hits", d_rd == 0, d_rd, 0);

    issue(1, 1, B, 32'h0BAD_F00D, 0, 0, 0, "R4 non-resident write");
    check("R4 one bus write non-resident", d_wr == 1, d_wr, 1);
    issue(0, 1, B, 0, 0, 32'h0BAD_F00D, 1, "R4 read after non-resident write");
    check("R4 no allocate on write", d_rd == 8, d_rd, 8);

    old = rd_model(A + 2);
    issue(1, 0, A + 2, 32'h1234_5678, 0, 0, 0, "R5 bypass write");
    check("R5 bypass starts next cycle", rise_cyc - acc_cyc == 1, rise_cyc - acc_cyc, 1);
    check("R5 bypass write on bus", d_wr == 1, d_wr, 1);
    issue(0, 1, A + 2, 0, 0, old, 1, "R5 cached copy untouched");
    check("R5 cached read hits", d_rd == 0, d_rd, 0);
    issue(0, 0, A + 2, 0, 0, 32'h1234_5678, 1, "R5 bypass read data");
    check("R5 bypass read single", d_rd == 1, d_rd, 1);

    issue(0, 1, C + 6, 0, 0, rd_model(C + 6), 1, "R3 conflicting line");
    check("R3 conflict fills", d_rd == 8, d_rd, 8);
    issue(0, 1, A + 1, 0, 0, rd_model(A + 1), 1, "R3 evicted line");
    check("R3 evicted line refills", d_rd == 8, d_rd, 8);

    err_on = 1'b1; err_addr = D + 3;
    issue(0, 1, D + 1, 0, 1, 0, 0, "R7 fill error");
    err_on = 1'b0;
    issue(0, 1, D + 1, 0, 0, rd_model(D + 1), 1, "R7 refill after error");
    check("R7 line invalid after error", d_rd == 8, d_rd, 8);

    // R9: held request during busy is ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    wr0 = n_wr; n0 = n_resp;
    req_valid = 1'b1; req_we = 1'b0; req_cacheable = 1'b1; req_addr = E; req_wdata = 0;
    exp_err_q.push_back(0); exp_dat_q.push_back(rd_model(E)); exp_chk_q.push_back(1);
    exp_req_q.push_back("R9 first request");
    @(negedge clk);
    req_we = 1'b1; req_cacheable = 1'b0; req_addr = F; req_wdata = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    check("R9 busy while held", busy, {31'd0, busy}, 1);
    req_valid = 1'b0;
    while (n_resp == n0) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R9 held write ignored", n_wr == wr0, n_wr - wr0, 0);
    check("R9 single response", n_resp == n0 + 1, n_resp - n0, 1);
    check("R10 bus idle at end", !wb_cyc, {31'd0, wb_cyc}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule